// File: doc/BRIEF.md
# Bus Handshake Compliance Monitor

This block sits beside one requester-responder link of a simple two-phase peripheral bus (the APB handshake) and watches it without driving any bus signal. Every cycle it sorts the bus into a phase: idle, setup, a waiting access, a completed access, or a stray enable without select. It then checks the phase against what the previous cycle allows. Each protocol rule has its own sticky flag. A one-cycle pulse marks the first failure since reset or since the last clear.

Beside the rule checks it keeps statistics: a count of transfers that completed cleanly, a count of transfers that completed with an error response, the wait-cycle count of the most recent transfer, and the largest wait count seen. All counters saturate at all-ones. All outputs are registered, so each one shows the result for a bus cycle one clock edge after that cycle is sampled.

Reset is synchronous and active high. A clear input empties the violation flags and leaves the statistics untouched.

Top module: `pbus_monitor`

## Requirements
- R1: `viol_flags` bit 0 sets when select and enable are both high in a cycle that follows an idle cycle, a completed access, or a stray-enable cycle. Enable must therefore be low in the first cycle of every transfer, including back-to-back ones.
- R2: `viol_flags` bit 1 sets when the address, write data, byte strobes, direction, select or enable differ from their values in the previous cycle, and that previous cycle was an access cycle with ready low.
- R3: `viol_flags` bit 2 sets when select is low in a cycle that follows either a setup cycle or an access cycle with ready low, meaning select was withdrawn before completion.
- R4: `viol_flags` bit 3 sets when the error input is high during an access cycle (select and enable high) in which ready is low.
- R5: `viol_flags` bit 4 sets when enable is high while select is low.
- R6: `viol_flags` bit 5 sets when select is high in the first cycle after reset is released.
- R7: `viol_flags` bit 6 sets when a setup cycle (select high, enable low) is followed by another cycle with select high and enable low.
- R8: Every flag bit is sticky. Only reset or `clr_flags` clears it. A rule failing in the same cycle as `clr_flags` is still recorded.
- R9: `viol_pulse` is high for exactly one cycle, in the cycle after a cycle in which some rule failed while no flag was set or `clr_flags` was high.
- R10: A cycle with select, enable and ready high is a completed transfer. It increments `err_count` if the error input is high, and `good_count` otherwise.
- R11: Each access cycle with ready low adds one to the running wait count. At completion that count is copied to `last_wait`, and `max_wait` keeps the largest such value.
- R12: `good_count`, `err_count`, the wait count, `last_wait` and `max_wait` hold at all-ones instead of wrapping.
- R13: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_flags | input | 1 | Clears all violation flags |
| bus_sel | input | 1 | Observed select |
| bus_enable | input | 1 | Observed enable (access phase marker) |
| bus_write | input | 1 | Observed direction, high for write |
| bus_addr | input | ADDR_W | Observed address |
| bus_wdata | input | DATA_W | Observed write data |
| bus_strb | input | DATA_W/8 | Observed byte strobes |
| bus_ready | input | 1 | Observed responder ready |
| bus_err | input | 1 | Observed responder error response |
| viol_flags | output | 7 | Sticky per-rule violation bits |
| viol_pulse | output | 1 | First-failure pulse |
| good_count | output | CNT_W | Clean completions, saturating |
| err_count | output | CNT_W | Error completions, saturating |
| max_wait | output | WAIT_W | Largest wait run seen |
| last_wait | output | WAIT_W | Wait run of the latest transfer |

## Verification
Properties check on every cycle that a stray enable, an error response without ready, a dropped select after setup, and a moved signal during a wait each raise their flag on the next edge. They also check that flags never fall without a clear, that the pulse never repeats while flags stay set, and that the clean-completion counter steps by one or holds at its ceiling. Some behaviour can only be shown by the bench's scenarios: the select-at-reset-release rule, a missing access phase, back-to-back transfers that must not trip the setup rule, exact wait-run lengths and their saturation, and the priority of a failure over a simultaneous clear. A randomized mix of legal and corrupted traffic exercises these against a bench-side model.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_WAIT  = 3'd2,
        PH_DONE  = 3'd3,
        PH_STRAY = 3'd4
    } phase_e;

    typedef struct packed {
        logic sel;
        logic en;
        logic ready;
        logic err;
    } hs_t;

    localparam int NUM_RULES     = 7;
    localparam int RULE_SETUP_EN = 0;
    localparam int RULE_HOLD     = 1;
    localparam int RULE_DROP     = 2;
    localparam int RULE_ERR      = 3;
    localparam int RULE_STRAY_EN = 4;
    localparam int RULE_RST_SEL  = 5;
    localparam int RULE_NO_ACC   = 6;

    function automatic phase_e classify(input logic sel, input logic en, input logic ready);
        if (!sel)        return en ? PH_STRAY : PH_IDLE;
        else if (!en)    return PH_SETUP;
        else if (!ready) return PH_WAIT;
        else             return PH_DONE;
    endfunction

    // After these phases a new transfer may begin, so enable must start low.
    function automatic logic opens_xfer(input phase_e p);
        return (p == PH_IDLE) || (p == PH_DONE) || (p == PH_STRAY);
    endfunction

    // After these phases the transfer is still in flight.
    function automatic logic mid_xfer(input phase_e p);
        return (p == PH_SETUP) || (p == PH_WAIT);
    endfunction

endpackage

// File: rtl/pmon_track.sv
module pmon_track
    import pmon_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sel,
    input  logic                   en,
    input  logic                   ready,
    input  logic                   write,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [DATA_W/8-1:0]    strb,
    output phase_e                 cur_ph,
    output phase_e                 prev_ph,
    output logic                   first_cyc,
    output logic                   held_moved
);
    localparam int STRB_W = DATA_W / 8;
    localparam int SNAP_W = ADDR_W + DATA_W + STRB_W + 3;

    logic [SNAP_W-1:0] snap_now;
    logic [SNAP_W-1:0] snap_prev;

    assign cur_ph     = classify(sel, en, ready);
    assign snap_now   = {addr, wdata, strb, write, sel, en};
    assign held_moved = (snap_now != snap_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ph   <= PH_IDLE;
            first_cyc <= 1'b1;
            snap_prev <= '0;
        end else begin
            prev_ph   <= cur_ph;
            first_cyc <= 1'b0;
            snap_prev <= snap_now;
        end
    end

endmodule

// File: rtl/pmon_rules.sv
module pmon_rules
    import pmon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  hs_t                  hs,
    input  phase_e               prev_ph,
    input  logic                 first_cyc,
    input  logic                 held_moved,
    output logic [NUM_RULES-1:0] flags,
    output logic                 pulse
);
    logic [NUM_RULES-1:0] fail;

    always_comb begin
        fail                = '0;
        fail[RULE_SETUP_EN] = hs.sel && hs.en && opens_xfer(prev_ph);
        fail[RULE_HOLD]     = (prev_ph == PH_WAIT) && held_moved;
        fail[RULE_DROP]     = !hs.sel && mid_xfer(prev_ph);
        fail[RULE_ERR]      = hs.sel && hs.en && !hs.ready && hs.err;
        fail[RULE_STRAY_EN] = hs.en && !hs.sel;
        fail[RULE_RST_SEL]  = first_cyc && hs.sel;
        fail[RULE_NO_ACC]   = (prev_ph == PH_SETUP) && hs.sel && !hs.en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            pulse <= 1'b0;
        end else begin
            flags <= (clr ? '0 : flags) | fail;
            pulse <= (|fail) && (clr || (flags == '0));
        end
    end

endmodule

// File: rtl/pmon_satcnt.sv
module pmon_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (inc && cnt != TOP)  cnt <= cnt + W'(1);
    end

endmodule

// File: rtl/pmon_stats.sv
module pmon_stats
    import pmon_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            cur_ph,
    input  logic              err,
    output logic [CNT_W-1:0]  good_cnt,
    output logic [CNT_W-1:0]  bad_cnt,
    output logic [WAIT_W-1:0] peak_wait,
    output logic [WAIT_W-1:0] recent_wait
);
    localparam int           N_TALLY  = 2;
    localparam logic [WAIT_W-1:0] WAIT_TOP = '1;

    logic [N_TALLY-1:0] bump;
    logic [CNT_W-1:0]   tally [N_TALLY];
    logic [WAIT_W-1:0]  run;

    assign bump[0] = (cur_ph == PH_DONE) && !err;
    assign bump[1] = (cur_ph == PH_DONE) && err;

    for (genvar g = 0; g < N_TALLY; g++) begin : g_tally
        pmon_satcnt #(.W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .inc (bump[g]),
            .cnt (tally[g])
        );
    end

    assign good_cnt = tally[0];
    assign bad_cnt  = tally[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            run         <= '0;
            recent_wait <= '0;
            peak_wait   <= '0;
        end else begin
            if (cur_ph == PH_WAIT) run <= (run == WAIT_TOP) ? run : run + WAIT_W'(1);
            else                   run <= '0;
            if (cur_ph == PH_DONE) begin
                recent_wait <= run;
                if (run > peak_wait) peak_wait <= run;
            end
        end
    end

endmodule

// File: rtl/pbus_monitor.sv
module pbus_monitor
    import pmon_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int WAIT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_flags,
    input  logic                 bus_sel,
    input  logic                 bus_enable,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [DATA_W/8-1:0]  bus_strb,
    input  logic                 bus_ready,
    input  logic                 bus_err,
    output logic [NUM_RULES-1:0] viol_flags,
    output logic                 viol_pulse,
    output logic [CNT_W-1:0]     good_count,
    output logic [CNT_W-1:0]     err_count,
    output logic [WAIT_W-1:0]    max_wait,
    output logic [WAIT_W-1:0]    last_wait
);
    phase_e cur_ph;
    phase_e prev_ph;
    logic   first_cyc;
    logic   held_moved;
    hs_t    hs;

    assign hs = '{sel: bus_sel, en: bus_enable, ready: bus_ready, err: bus_err};

    pmon_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .sel        (bus_sel),
        .en         (bus_enable),
        .ready      (bus_ready),
        .write      (bus_write),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .strb       (bus_strb),
        .cur_ph     (cur_ph),
        .prev_ph    (prev_ph),
        .first_cyc  (first_cyc),
        .held_moved (held_moved)
    );

    pmon_rules u_rules (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr_flags),
        .hs         (hs),
        .prev_ph    (prev_ph),
        .first_cyc  (first_cyc),
        .held_moved (held_moved),
        .flags      (viol_flags),
        .pulse      (viol_pulse)
    );

    pmon_stats #(.CNT_W(CNT_W), .WAIT_W(WAIT_W)) u_stats (
        .clk         (clk),
        .rst         (rst),
        .cur_ph      (cur_ph),
        .err         (bus_err),
        .good_cnt    (good_count),
        .bad_cnt     (err_count),
        .peak_wait   (max_wait),
        .recent_wait (last_wait)
    );

endmodule

// File: rtl/pmon_checker.sv
module pmon_checker
    import pmon_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int WAIT_W = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 clr_flags,
    input logic                 bus_sel,
    input logic                 bus_enable,
    input logic                 bus_write,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W/8-1:0]  bus_strb,
    input logic                 bus_ready,
    input logic                 bus_err,
    input logic [NUM_RULES-1:0] viol_flags,
    input logic                 viol_pulse,
    input logic [CNT_W-1:0]     good_count,
    input logic [CNT_W-1:0]     err_count,
    input logic [WAIT_W-1:0]    max_wait,
    input logic [WAIT_W-1:0]    last_wait
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_enable && !bus_ready) ##1
        ({bus_addr, bus_wdata, bus_strb, bus_write} != $past({bus_addr, bus_wdata, bus_strb, bus_write}))
        |=> viol_flags[RULE_HOLD]);

    p_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_enable) ##1 !bus_sel |=> viol_flags[RULE_DROP]);

    p_err_wait_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_enable && !bus_ready && bus_err) |=> viol_flags[RULE_ERR]);

    p_stray_en_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_enable && !bus_sel) |=> viol_flags[RULE_STRAY_EN]);

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !clr_flags |=> ((viol_flags & $past(viol_flags)) == $past(viol_flags)));

    p_pulse_flag_r9: assert property (@(posedge clk) disable iff (rst)
        viol_pulse |-> (viol_flags != '0));

    p_pulse_once_r9: assert property (@(posedge clk) disable iff (rst)
        (viol_pulse && !clr_flags) |=> !viol_pulse);

    p_good_step_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_enable && bus_ready && !bus_err && good_count != CNT_TOP)
        |=> good_count == $past(good_count) + CNT_W'(1));

    p_err_step_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_enable && bus_ready && bus_err && err_count != CNT_TOP)
        |=> err_count == $past(err_count) + CNT_W'(1));

    p_peak_r11: assert property (@(posedge clk) disable iff (rst)
        last_wait <= max_wait);

    p_sat_r12: assert property (@(posedge clk) disable iff (rst)
        (good_count == CNT_TOP) |=> (good_count == CNT_TOP));

endmodule

bind pbus_monitor pmon_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .WAIT_W (WAIT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_flags  (clr_flags),
    .bus_sel    (bus_sel),
    .bus_enable (bus_enable),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_strb   (bus_strb),
    .bus_ready  (bus_ready),
    .bus_err    (bus_err),
    .viol_flags (viol_flags),
    .viol_pulse (viol_pulse),
    .good_count (good_count),
    .err_count  (err_count),
    .max_wait   (max_wait),
    .last_wait  (last_wait)
);

// File: tb/pbus_monitor_tb.sv
`timescale 1ns/1ps
module pbus_monitor_tb;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SW = DW / 8;
    localparam int CW = 4;
    localparam int WW = 3;
    localparam int NR = 7;
    localparam int CMAX = (1 << CW) - 1;
    localparam int WMAX = (1 << WW) - 1;
    localparam int SNW  = AW + DW + SW + 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst = 1'b1, clr = 1'b0;
    logic          sel = 1'b0, en = 1'b0, wr = 1'b0, rdy = 1'b0, err = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [SW-1:0] strb = '0;

    logic [NR-1:0] flags;
    logic          pulse;
    logic [CW-1:0] good_c, err_c;
    logic [WW-1:0] max_w, last_w;

    pbus_monitor #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .WAIT_W(WW)) u_dut (
        .clk(clk), .rst(rst), .clr_flags(clr),
        .bus_sel(sel), .bus_enable(en), .bus_write(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_strb(strb), .bus_ready(rdy), .bus_err(err),
        .viol_flags(flags), .viol_pulse(pulse), .good_count(good_c),
        .err_count(err_c), .max_wait(max_w), .last_wait(last_w)
    );

    int checks = 0;
    int errors = 0;

    // Bench model state; phase codes: 0 idle, 1 setup, 2 wait, 3 done, 4 stray
    int            m_prev = 0;
    bit            m_first = 1'b1;
    logic [SNW-1:0] m_snap = '0;
    logic [NR-1:0] m_flags = '0;
    bit            m_pulse = 1'b0;
    int            m_good = 0, m_err = 0, m_run = 0, m_last = 0, m_max = 0;

    function automatic int sat(input int v, input int top);
        return (v > top) ? top : v;
    endfunction

    task automatic expect_eq(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        logic [NR-1:0]  f;
        logic [SNW-1:0] snap;
        int             cur;
        snap = {addr, wdata, strb, wr, sel, en};
        if (rst) begin
            m_prev = 0; m_first = 1'b1; m_snap = '0; m_flags = '0; m_pulse = 1'b0;
            m_good = 0; m_err = 0; m_run = 0; m_last = 0; m_max = 0;
        end else begin
            f    = '0;
            f[0] = sel && en && (m_prev == 0 || m_prev == 3 || m_prev == 4);
            f[1] = (m_prev == 2) && (snap != m_snap);
            f[2] = !sel && (m_prev == 1 || m_prev == 2);
            f[3] = sel && en && !rdy && err;
            f[4] = en && !sel;
            f[5] = m_first && sel;
            f[6] = (m_prev == 1) && sel && !en;
            m_pulse = (f != '0) && (clr || m_flags == '0);
            m_flags = (clr ? '0 : m_flags) | f;
            cur = !sel ? (en ? 4 : 0) : (!en ? 1 : (!rdy ? 2 : 3));
            if (cur == 3) begin
                if (err) m_err = sat(m_err + 1, CMAX);
                else     m_good = sat(m_good + 1, CMAX);
                m_last = m_run;
                if (m_run > m_max) m_max = m_run;
            end
            m_run   = (cur == 2) ? sat(m_run + 1, WMAX) : 0;
            m_prev  = cur;
            m_first = 1'b0;
            m_snap  = snap;
        end
        @(posedge clk);
        #1;
        expect_eq("R8",  "flags",     flags,  m_flags);
        expect_eq("R9",  "pulse",     pulse,  m_pulse);
        expect_eq("R10", "good",      good_c, m_good);
        expect_eq("R10", "errcnt",    err_c,  m_err);
        expect_eq("R11", "last_wait", last_w, m_last);
        expect_eq("R11", "max_wait",  max_w,  m_max);
    endtask

    task automatic bus(input bit s, input bit e, input bit r, input bit x);
        sel = s; en = e; rdy = r; err = x;
        step();
    endtask

    task automatic do_reset(input bit hold_sel);
        rst = 1'b1; clr = 1'b0;
        sel = hold_sel; en = 1'b0; rdy = 1'b0; err = 1'b0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic xfer(input bit w, input int waits, input bit x);
        wr = w; addr = AW'($urandom); wdata = $urandom; strb = SW'($urandom);
        bus(1, 0, 0, 0);
        for (int i = 0; i < waits; i++) bus(1, 1, 0, 0);
        bus(1, 1, 1, x);
        sel = 1'b0; en = 1'b0; rdy = 1'b0; err = 1'b0;
    endtask

    task automatic clear_now();
        clr = 1'b1; bus(0, 0, 0, 0); clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));

        // R13: reset state
        do_reset(0);
        expect_eq("R13", "flags after reset", flags, 0);
        expect_eq("R13", "good after reset", good_c, 0);
        expect_eq("R13", "max after reset", max_w, 0);
        bus(0, 0, 0, 0);

        // R10: clean write, zero waits
        xfer(1, 0, 0);
        expect_eq("R10", "good after write", good_c, 1);
        expect_eq("R10", "no flags legal", flags, 0);

        // R11 / R10: read with three waits ending in error
        xfer(0, 3, 1);
        expect_eq("R10", "err after error read", err_c, 1);
        expect_eq("R11", "last_wait 3", last_w, 3);
        expect_eq("R11", "max_wait 3", max_w, 3);
        // back-to-back legal transfers must stay clean (R1)
        xfer(1, 1, 0); xfer(0, 0, 0);
        expect_eq("R1", "back-to-back clean", flags, 0);
        expect_eq("R11", "last_wait 0", last_w, 0);

        // R1: enable high in the first select cycle
        bus(0, 0, 0, 0);
        bus(1, 1, 1, 0);
        expect_eq("R1", "setup enable flag", flags, 7'b0000001);
        expect_eq("R9", "pulse on first failure", pulse, 1);
        bus(0, 0, 0, 0);
        expect_eq("R9", "pulse one cycle", pulse, 0);
        clear_now();
        expect_eq("R8", "cleared", flags, 0);

        // R2: address moves during wait
        addr = 16'h0100;
        bus(1, 0, 0, 0); bus(1, 1, 0, 0);
        addr = 16'h0104;
        bus(1, 1, 0, 0);
        expect_eq("R2", "hold flag", flags, 7'b0000010);
        bus(1, 1, 1, 0); bus(0, 0, 0, 0); clear_now();

        // R3: select withdrawn after setup
        bus(1, 0, 0, 0); bus(0, 0, 0, 0);
        expect_eq("R3", "drop flag", flags, 7'b0000100);
        clear_now();

        // R4: error with ready low
        bus(1, 0, 0, 0); bus(1, 1, 0, 1);
        expect_eq("R4", "err without ready", flags, 7'b0001000);
        bus(1, 1, 1, 0); bus(0, 0, 0, 0); clear_now();

        // R5: enable without select
        bus(0, 1, 0, 0);
        expect_eq("R5", "stray enable", flags, 7'b0010000);
        clear_now();

        // R7: setup repeated
        bus(1, 0, 0, 0); bus(1, 0, 0, 0);
        expect_eq("R7", "missing access", flags, 7'b1000000);
        bus(1, 1, 1, 0); bus(0, 0, 0, 0); clear_now();

        // R8: failure in the clear cycle survives
        clr = 1'b1; bus(0, 1, 0, 0); clr = 1'b0;
        expect_eq("R8", "fail beats clear", flags, 7'b0010000);
        expect_eq("R9", "pulse with clear", pulse, 1);
        bus(0, 0, 0, 0);
        expect_eq("R8", "still sticky", flags, 7'b0010000);
        clear_now();

        // R6: select high at reset release
        do_reset(1);
        bus(1, 0, 0, 0);
        expect_eq("R6", "select at release", flags, 7'b0100000);
        bus(1, 1, 1, 0);
        expect_eq("R10", "good after release xfer", good_c, 1);
        bus(0, 0, 0, 0);

        // R12: saturation of counters and wait run
        for (int i = 0; i < 20; i++) xfer(1, 0, 0);
        expect_eq("R12", "good saturates", good_c, CMAX);
        xfer(0, 10, 0);
        expect_eq("R12", "last_wait saturates", last_w, WMAX);
        expect_eq("R12", "max_wait saturates", max_w, WMAX);
        bus(0, 0, 0, 0);

        // Randomized mix checked against the model each cycle
        do_reset(0);
        for (int it = 0; it < 2500; it++) begin
            int r;
            r = $urandom_range(0, 19);
            if (r < 13) begin
                xfer($urandom_range(0, 1), $urandom_range(0, 4), ($urandom_range(0, 3) == 0));
            end else if (r < 16) begin
                addr = AW'($urandom); wdata = $urandom; strb = SW'($urandom);
                bus(0, 0, $urandom_range(0, 1), 0);
            end else if (r < 18) begin
                addr = AW'($urandom); wr = $urandom_range(0, 1);
                clr = ($urandom_range(0, 3) == 0);
                bus($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
                clr = 1'b0;
            end else if (r == 18) begin
                clear_now();
            end else begin
                do_reset($urandom_range(0, 1));
            end
        end
        bus(0, 0, 0, 0);

        finish_run();
    end

endmodule